// File: doc/BRIEF.md
# Nine-State Shift Bit Counter

This block counts how many bits an 8-bit serial shift register has moved, from zero to eight. There is no binary adder and no exclusive-OR feedback. A 5-bit twisted ring holds the count: the complement of the top stage shifts into the bottom stage. The ring has nine reachable states, so "nothing shifted yet" and "all eight shifted" are distinct. A transfer controller pulses an advance input once per shifted bit. It watches a done output to end the transfer, which it may also use to raise an interrupt. It pulses a clear input to start the next transfer.

Both controls act only in the low half of the clock. The state register samples them on the falling clock edge and updates on that same edge. A pulse that rises and falls within the high half has no effect.

The state machine names its nine states E0 to E8, with ring codes E0=00000, E1=00001, E2=00011, E3=00111, E4=01111, E5=11111, E6=11110, E7=11100, E8=11000.

Transitions on a falling edge:
- ADVANCE: with advance high and clear low, En moves to En+1 for n from 0 to 7.
- PARK: with advance high and clear low, E8 stays in E8.
- CLEAR: with clear high, any state moves to E0, whatever advance is.
- HOLD: with both controls low, the state is unchanged.

An asynchronous active-low reset forces E0.

Top module: `shift_tally9`

## Requirements
- R1: While rst_n is low and right after it is released, tally_count is 0 and tally_done is 0.
- R2: A falling edge with shift_adv=1 and shift_clr=0 moves the state one step along E0..E8. tally_count reports the step number as unsigned binary, 0 in E0 through 8 in E8.
- R3: tally_done is 1 exactly when the state is E8, which is when tally_count equals 8.
- R4: In E8, shift_adv has no effect. tally_count stays 8 and tally_done stays 1 until a clear or a reset.
- R5: A falling edge with shift_clr=1 returns the state to E0 (count 0, done 0) from any state, including E8. Counting restarts normally afterwards.
- R6: When shift_clr and shift_adv are both 1 at a falling edge, the clear wins and the state becomes E0.
- R7: A falling edge with both controls at 0 leaves tally_count and tally_done unchanged.
- R8: A pulse on shift_adv or shift_clr that starts after a rising edge and ends before the next falling edge has no effect on the outputs.
- R9: The outputs change only after a falling clock edge or after a reset. They are unchanged across a rising edge, even while shift_adv is held high.
- R10: Pulling rst_n low mid-count clears the outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state register acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset to E0 |
| shift_adv | input | 1 | Advance by one bit, sampled at the falling edge |
| shift_clr | input | 1 | Return to zero, sampled at the falling edge; wins over shift_adv |
| tally_done | output | 1 | High while eight bits have been counted (state E8) |
| tally_count | output | 4 | Decoded number of bits shifted, 0 to 8 |

## Verification
Both outputs decode combinationally from the ring. A wrong state therefore appears at tally_count within the same low half-cycle as the falling edge that loaded it. A wrong next-state entry shows one falling edge after the stimulus that should have used it. A fault in the PARK transition or in the done gate shows only when the count reaches E8, or when advance continues there. The stimulus therefore runs complete eight-bit transfers, over-runs them, and clears from the parked state.

// File: rtl/tally9_pkg.sv
package tally9_pkg;

    // Bits moved by one serial transfer.
    localparam int XFER_BITS = 8;
    // A twisted ring of W stages has 2*W states; XFER_BITS+1 are needed.
    localparam int CHAIN_W   = (XFER_BITS + 2) / 2;
    localparam int COUNT_W   = $clog2(XFER_BITS + 1);
    localparam logic [COUNT_W-1:0] LAST_COUNT = COUNT_W'(XFER_BITS);

    // Reachable ring codes, named by the number of bits counted.
    typedef enum logic [CHAIN_W-1:0] {
        ST_E0 = 5'b00000,
        ST_E1 = 5'b00001,
        ST_E2 = 5'b00011,
        ST_E3 = 5'b00111,
        ST_E4 = 5'b01111,
        ST_E5 = 5'b11111,
        ST_E6 = 5'b11110,
        ST_E7 = 5'b11100,
        ST_E8 = 5'b11000
    } tally_state_e;

endpackage

// File: rtl/tally9_ring.sv
module tally9_ring
    import tally9_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         clr,
    output tally_state_e state
);

    tally_state_e cur;
    tally_state_e step;
    tally_state_e nxt;

    // Successor along the ring; E8 parks instead of wrapping.
    always_comb begin
        unique case (cur)
            ST_E0:   step = ST_E1;
            ST_E1:   step = ST_E2;
            ST_E2:   step = ST_E3;
            ST_E3:   step = ST_E4;
            ST_E4:   step = ST_E5;
            ST_E5:   step = ST_E6;
            ST_E6:   step = ST_E7;
            ST_E7:   step = ST_E8;
            ST_E8:   step = ST_E8;
            default: step = cur;
        endcase
    end

    // Clear outranks advance; an unreachable code waits for a clear.
    always_comb begin
        if (clr)
            nxt = ST_E0;
        else if (adv)
            nxt = step;
        else
            nxt = cur;
    end

    // Low-phase action: controls sampled and state loaded on the falling edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            cur <= ST_E0;
        else
            cur <= nxt;
    end

    assign state = cur;

    // R2: each advance below E8 flips exactly one ring stage.
    a_r2_single_flip: assert property (@(negedge clk) disable iff (!rst_n)
        (adv && !clr && cur != ST_E8) |=> ($countones(cur ^ $past(cur)) == 1));

    // R6: a clear with a simultaneous advance lands in E0.
    a_r6_clr_wins: assert property (@(negedge clk) disable iff (!rst_n)
        (adv && clr) |=> (cur == ST_E0));

endmodule

// File: rtl/tally9_decode.sv
module tally9_decode
    import tally9_pkg::*;
#(
    parameter bit FULL_DONE_DECODE = 1'b0
) (
    input  tally_state_e       state,
    output logic [COUNT_W-1:0] count,
    output logic               done
);

    // Count readout, one arm per state.
    always_comb begin
        unique case (state)
            ST_E0:   count = COUNT_W'(0);
            ST_E1:   count = COUNT_W'(1);
            ST_E2:   count = COUNT_W'(2);
            ST_E3:   count = COUNT_W'(3);
            ST_E4:   count = COUNT_W'(4);
            ST_E5:   count = COUNT_W'(5);
            ST_E6:   count = COUNT_W'(6);
            ST_E7:   count = COUNT_W'(7);
            ST_E8:   count = COUNT_W'(8);
            default: count = '0;
        endcase
    end

    generate
        if (FULL_DONE_DECODE) begin : g_done_full
            assign done = (state == ST_E8);
        end else begin : g_done_pair
            // Among reachable codes only E8 has the top stage set and stage 2 clear.
            assign done = state[CHAIN_W-1] & ~state[CHAIN_W-3];
        end
    endgenerate

endmodule

// File: rtl/shift_tally9.sv
module shift_tally9
    import tally9_pkg::*;
#(
    parameter bit FULL_DONE_DECODE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_adv,
    input  logic               shift_clr,
    output logic               tally_done,
    output logic [COUNT_W-1:0] tally_count
);

    tally_state_e ring_state;

    tally9_ring u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (shift_adv),
        .clr   (shift_clr),
        .state (ring_state)
    );

    tally9_decode #(
        .FULL_DONE_DECODE (FULL_DONE_DECODE)
    ) u_decode (
        .state (ring_state),
        .count (tally_count),
        .done  (tally_done)
    );

    // R2: an advance below eight raises the count by one.
    a_r2_count_up: assert property (@(negedge clk) disable iff (!rst_n)
        (shift_adv && !shift_clr && !tally_done)
        |=> (tally_count == $past(tally_count) + 1'b1));

    // R3: the done gate agrees with the count readout.
    a_r3_done_at_eight: assert property (@(negedge clk) disable iff (!rst_n)
        (tally_done == (tally_count == LAST_COUNT)));

    // R4: the parked state survives any edge without a clear.
    a_r4_park: assert property (@(negedge clk) disable iff (!rst_n)
        (tally_done && !shift_clr) |=> (tally_done && tally_count == LAST_COUNT));

    // R5: a clear empties the counter.
    a_r5_clr_zero: assert property (@(negedge clk) disable iff (!rst_n)
        shift_clr |=> (tally_count == '0 && !tally_done));

    // R7: an idle edge holds the count.
    a_r7_idle_hold: assert property (@(negedge clk) disable iff (!rst_n)
        (!shift_adv && !shift_clr) |=> $stable(tally_count));

endmodule

// File: tb/sim_shift_tally9.sv
`timescale 1ns/1ps
module sim_shift_tally9;
    import tally9_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adv = 1'b0;
    logic clr = 1'b0;
    logic done;
    logic [COUNT_W-1:0] cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    shift_tally9 u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_adv   (adv),
        .shift_clr   (clr),
        .tally_done  (done),
        .tally_count (cnt)
    );

    task automatic check(input string tag, input logic [COUNT_W-1:0] ec, input logic ed);
        n_chk++;
        if (cnt !== ec || done !== ed) begin
            n_bad++;
            $display("FAIL %s: count=%0d done=%b, expected count=%0d done=%b",
                     tag, cnt, done, ec, ed);
        end
    endtask

    // Inputs change 1 ns into the high phase; outputs are read 1 ns after the falling edge.
    task automatic drive(input logic a, input logic c);
        @(posedge clk);
        #1;
        adv = a;
        clr = c;
        @(negedge clk);
        #1;
    endtask

    function automatic string tag_of(input logic [3:0] t);
        case (t)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            default: return "R?";
        endcase
    endfunction

    // Fields: {requirement, clr, adv, expected count, expected done}
    localparam int NV = 21;
    localparam logic [10:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b1, 4'd1, 1'b0},  // R2
        {4'd2, 1'b0, 1'b1, 4'd2, 1'b0},  // R2
        {4'd2, 1'b0, 1'b1, 4'd3, 1'b0},  // R2
        {4'd7, 1'b0, 1'b0, 4'd3, 1'b0},  // R7 idle
        {4'd2, 1'b0, 1'b1, 4'd4, 1'b0},  // R2
        {4'd5, 1'b1, 1'b0, 4'd0, 1'b0},  // R5 clear mid-count
        {4'd2, 1'b0, 1'b1, 4'd1, 1'b0},  // R2
        {4'd6, 1'b1, 1'b1, 4'd0, 1'b0},  // R6 clear beats advance
        {4'd2, 1'b0, 1'b1, 4'd1, 1'b0},  // R2 full transfer
        {4'd2, 1'b0, 1'b1, 4'd2, 1'b0},
        {4'd2, 1'b0, 1'b1, 4'd3, 1'b0},
        {4'd2, 1'b0, 1'b1, 4'd4, 1'b0},
        {4'd2, 1'b0, 1'b1, 4'd5, 1'b0},
        {4'd2, 1'b0, 1'b1, 4'd6, 1'b0},
        {4'd2, 1'b0, 1'b1, 4'd7, 1'b0},
        {4'd3, 1'b0, 1'b1, 4'd8, 1'b1},  // R3 done at eight
        {4'd4, 1'b0, 1'b1, 4'd8, 1'b1},  // R4 over-run ignored
        {4'd4, 1'b0, 1'b1, 4'd8, 1'b1},  // R4
        {4'd7, 1'b0, 1'b0, 4'd8, 1'b1},  // R7 idle while parked
        {4'd5, 1'b1, 1'b0, 4'd0, 1'b0},  // R5 clear from E8
        {4'd5, 1'b0, 1'b1, 4'd1, 1'b0}   // R5 restart after clear
    };

    initial begin
        // R1: reset state, while held and after release
        #7;
        check("R1", 4'd0, 1'b0);
        repeat (2) @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1", 4'd0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][5], VEC[i][6]);
            check(tag_of(VEC[i][10:7]), VEC[i][4:1], VEC[i][0]);
        end

        // R8: pulses confined to the high phase (count is 1 here)
        @(posedge clk);
        #0.5 adv = 1'b1;
        #1   adv = 1'b0;
        @(negedge clk);
        #1;
        check("R8", 4'd1, 1'b0);
        @(posedge clk);
        #0.5 clr = 1'b1;
        #1   clr = 1'b0;
        @(negedge clk);
        #1;
        check("R8", 4'd1, 1'b0);

        // R9: advance held high; nothing moves at the rising edge
        drive(1'b1, 1'b0);
        check("R2", 4'd2, 1'b0);
        @(posedge clk);
        #1;
        check("R9", 4'd2, 1'b0);
        @(negedge clk);
        #1;
        check("R2", 4'd3, 1'b0);
        adv = 1'b0;

        // R10: asynchronous reset mid-count
        @(posedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        check("R10", 4'd0, 1'b0);
        @(negedge clk);
        #1 rst_n = 1'b1;
        check("R10", 4'd0, 1'b0);

        // R6 again from a deeper state
        repeat (5) drive(1'b1, 1'b0);
        check("R2", 4'd5, 1'b0);
        drive(1'b1, 1'b1);
        check("R6", 4'd0, 1'b0);
        drive(1'b0, 1'b0);
        check("R7", 4'd0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #20000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule